// File: doc/BRIEF.md
# Discriminator Pulse Stretcher and Shaper

This block holds the per-channel digital shaping logic of a photomultiplier front end. Each channel takes four asynchronous discriminator levels: a low and a high timing threshold, a counting threshold and a trigger threshold. It drives three outputs. The timing output is for a time-to-digital converter, and the counting and trigger outputs are stretched copies. Every output rises through a purely combinational path from the discriminator input, so the leading edge carries no clock quantisation. Only the trailing extension is counted, in ticks of the fast shaping clock (5 ns at 200 MHz). It passes through a two-flop synchroniser before it reaches any counter.

The timing output has two guarantees. A low-threshold pulse is stretched to a minimum width. Once the high-threshold level drops, the output is held for a programmed number of ticks. If the low-threshold level is still present after that hold, the output follows it down. The counting and trigger outputs each have their own stretch length. Every channel can be silenced with a disable bit.

A small write-only register port sets four shared stretch lengths and the per-channel disable mask. The channel count is a parameter. `NCH` must not exceed `DW`.

Top module: `pulse_shaper`

## Requirements
- R1: After reset, all outputs are low while the inputs are low. The lengths reset to: minimum width 5, high hold 8, count stretch 5, trigger stretch 5. All channels reset enabled.
- R2: While a channel is enabled, a high level on its low or high timing input drives `time_o` high in the same instant, with no clock edge in between. The counting input drives `count_o` the same way, and the trigger input drives `trig_o`.
- R3: Let k be the clock edge at which the low timing input is first sampled high after having been sampled low. `time_o` then stays high at least until clock edge k+2+L, where L is the minimum-width length. It drops after that edge if no other term holds it.
- R4: Let j be the last clock edge at which the high timing input was sampled high. `time_o` stays high until clock edge j+2+H, where H is the hold length.
- R5: If the low timing input is still high when the hold of R4 ends, `time_o` follows that input and falls only when it falls.
- R6: `count_o` and `trig_o` follow the rule of R3, driven by their own inputs and each with its own length register.
- R7: A new rising edge during an active stretch restarts the count, so the stretch ends L ticks after the latest edge.
- R8: A length field written as 0 behaves as a length of 1.
- R9: Setting bit c of the disable mask forces all three outputs of channel c low from the clock edge that takes the write. Other channels are unaffected.
- R10: Writes go through `cfg_we_i`, `cfg_addr_i` and `cfg_wdata_i` and take effect at the clock edge that samples them. The map is: address 0 is the minimum width, 1 the high hold, 2 the count stretch and 3 the trigger stretch, each in data bits 7:0. Address 4 is the disable mask in bits NCH-1:0, where 1 means disabled. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shaping clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | DW | Register write data |
| disc_lo_i | input | NCH | Low timing threshold levels |
| disc_hi_i | input | NCH | High timing threshold levels |
| disc_cnt_i | input | NCH | Counting threshold levels |
| disc_trg_i | input | NCH | Trigger threshold levels |
| time_o | output | NCH | Shaped timing outputs |
| count_o | output | NCH | Stretched counting outputs |
| trig_o | output | NCH | Stretched trigger outputs |

## Verification
A stretch counter that loads the wrong length or decrements wrongly moves the trailing edge of that output. The move shows within L+2 cycles of the first rising edge that uses it. A dropped reload shows as an output falling early during a burst of closely spaced pulses. A mask bit in the wrong place shows on the cycle after the write, as a disabled channel driving high or an enabled one staying silent. The bench compares every output of every channel against an edge-exact model on every cycle, so each of these faults surfaces on the first cycle it affects.

// File: rtl/pstr_pkg.sv
package pstr_pkg;
  localparam int LEN_W  = 8;
  localparam int ADDR_W = 3;

  typedef logic [LEN_W-1:0] len_t;

  typedef struct packed {
    len_t min_lo;
    len_t hold_hi;
    len_t cnt;
    len_t trg;
  } len_cfg_t;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MIN  = 3'd0,
    ADDR_HOLD = 3'd1,
    ADDR_CNT  = 3'd2,
    ADDR_TRG  = 3'd3,
    ADDR_MASK = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pstr_sync.sv
module pstr_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q;
endmodule

// File: rtl/pstr_stretch.sv
module pstr_stretch import pstr_pkg::*; #(
  parameter bit LEVEL       = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  len_t len_i,
  input  logic raw_i,
  output logic held_o
);
  logic [SYNC_STAGES-1:0] sync;
  logic s_first, s_last, load;
  len_t cnt_q, len_eff;

  pstr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync)
  );

  assign s_first = sync[0];
  assign s_last  = sync[SYNC_STAGES-1];

  generate
    if (LEVEL) begin : g_level
      // reload every cycle the level is present; hold counts from its fall
      assign load = s_last;
    end else begin : g_edge
      logic s_dly_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_dly_q <= 1'b0;
        else         s_dly_q <= s_last;
      end
      assign load = s_last & ~s_dly_q;
    end
  endgenerate

  assign len_eff = (len_i == '0) ? len_t'(1) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (load)         cnt_q <= len_eff;
    else if (cnt_q != '0)  cnt_q <= cnt_q - len_t'(1);
  end

  // sync taps bridge the gap between the raw edge and the counter load
  assign held_o = s_first | load | (cnt_q != '0);
endmodule

// File: rtl/pstr_chan.sv
module pstr_chan import pstr_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  len_cfg_t len_i,
  input  logic     lo_i,
  input  logic     hi_i,
  input  logic     cnt_i,
  input  logic     trg_i,
  output logic     time_o,
  output logic     count_o,
  output logic     trig_o
);
  logic lo_held, hi_held, cnt_held, trg_held;

  pstr_stretch #(.LEVEL(1'b0)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .len_i(len_i.min_lo), .raw_i(lo_i), .held_o(lo_held)
  );

  pstr_stretch #(.LEVEL(1'b1)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .len_i(len_i.hold_hi), .raw_i(hi_i), .held_o(hi_held)
  );

  pstr_stretch #(.LEVEL(1'b0)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .len_i(len_i.cnt), .raw_i(cnt_i), .held_o(cnt_held)
  );

  pstr_stretch #(.LEVEL(1'b0)) u_trg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .len_i(len_i.trg), .raw_i(trg_i), .held_o(trg_held)
  );

  // leading edges are unclocked; only the tails come from counters
  assign time_o  = en_i & (lo_i | hi_i | lo_held | hi_held);
  assign count_o = en_i & (cnt_i | cnt_held);
  assign trig_o  = en_i & (trg_i | trg_held);
endmodule

// File: rtl/pstr_regs.sv
module pstr_regs import pstr_pkg::*; #(
  parameter int   NCH         = 9,
  parameter int   DW          = 16,
  parameter len_t MIN_LO_RST  = 8'd5,
  parameter len_t HOLD_HI_RST = 8'd8,
  parameter len_t CNT_RST     = 8'd5,
  parameter len_t TRG_RST     = 8'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output len_cfg_t          len_o,
  output logic [NCH-1:0]    dis_o
);
  len_cfg_t       len_q;
  logic [NCH-1:0] dis_q;
  logic           unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q.min_lo  <= MIN_LO_RST;
      len_q.hold_hi <= HOLD_HI_RST;
      len_q.cnt     <= CNT_RST;
      len_q.trg     <= TRG_RST;
      dis_q         <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_MIN:  len_q.min_lo  <= wdata_i[LEN_W-1:0];
        ADDR_HOLD: len_q.hold_hi <= wdata_i[LEN_W-1:0];
        ADDR_CNT:  len_q.cnt     <= wdata_i[LEN_W-1:0];
        ADDR_TRG:  len_q.trg     <= wdata_i[LEN_W-1:0];
        ADDR_MASK: dis_q         <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  assign len_o = len_q;
  assign dis_o = dis_q;
endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper import pstr_pkg::*; #(
  parameter int   NCH         = 9,
  parameter int   DW          = 16,
  parameter len_t MIN_LO_RST  = 8'd5,
  parameter len_t HOLD_HI_RST = 8'd8,
  parameter len_t CNT_RST     = 8'd5,
  parameter len_t TRG_RST     = 8'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  input  logic [NCH-1:0]    disc_lo_i,
  input  logic [NCH-1:0]    disc_hi_i,
  input  logic [NCH-1:0]    disc_cnt_i,
  input  logic [NCH-1:0]    disc_trg_i,
  output logic [NCH-1:0]    time_o,
  output logic [NCH-1:0]    count_o,
  output logic [NCH-1:0]    trig_o
);
  len_cfg_t       len_cfg;
  logic [NCH-1:0] dis_q;

  pstr_regs #(
    .NCH(NCH), .DW(DW),
    .MIN_LO_RST(MIN_LO_RST), .HOLD_HI_RST(HOLD_HI_RST),
    .CNT_RST(CNT_RST), .TRG_RST(TRG_RST)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .len_o  (len_cfg),
    .dis_o  (dis_q)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      pstr_chan u_chan (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (~dis_q[c]),
        .len_i  (len_cfg),
        .lo_i   (disc_lo_i[c]),
        .hi_i   (disc_hi_i[c]),
        .cnt_i  (disc_cnt_i[c]),
        .trg_i  (disc_trg_i[c]),
        .time_o (time_o[c]),
        .count_o(count_o[c]),
        .trig_o (trig_o[c])
      );
    end
  endgenerate
endmodule

// File: rtl/pulse_shaper_chk.sv
module pulse_shaper_chk import pstr_pkg::*; #(
  parameter int NCH = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] disc_lo_i,
  input logic [NCH-1:0] disc_hi_i,
  input logic [NCH-1:0] disc_cnt_i,
  input logic [NCH-1:0] disc_trg_i,
  input logic [NCH-1:0] time_i,
  input logic [NCH-1:0] count_i,
  input logic [NCH-1:0] trig_i,
  input logic [NCH-1:0] dis_i,
  input len_cfg_t       len_i
);
  localparam int SW = LEN_W + 2;
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0] min_eff, hold_eff;
  assign min_eff  = (len_i.min_lo  == '0) ? SW'(1) : SW'(len_i.min_lo);
  assign hold_eff = (len_i.hold_hi == '0) ? SW'(1) : SW'(len_i.hold_hi);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_c
      logic          lo_prev_q;
      logic [SW-1:0] lo_since_q, hi_since_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_prev_q  <= 1'b0;
          lo_since_q <= '0;
          hi_since_q <= '0;
        end else begin
          lo_prev_q <= disc_lo_i[c];
          if (dis_i[c])                          lo_since_q <= '0;
          else if (disc_lo_i[c] && !lo_prev_q)   lo_since_q <= SW'(1);
          else if (lo_since_q != '0 && lo_since_q != SMAX) lo_since_q <= lo_since_q + SW'(1);
          if (dis_i[c])                          hi_since_q <= '0;
          else if (disc_hi_i[c])                 hi_since_q <= SW'(1);
          else if (hi_since_q != '0 && hi_since_q != SMAX) hi_since_q <= hi_since_q + SW'(1);
        end
      end

      a_r9_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dis_i[c] |-> (!time_i[c] && !count_i[c] && !trig_i[c]));

      a_r2_lead_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dis_i[c] && (disc_lo_i[c] || disc_hi_i[c] || disc_cnt_i[c] || disc_trg_i[c]))
        |-> ((time_i[c] || !(disc_lo_i[c] || disc_hi_i[c]))
             && (count_i[c] || !disc_cnt_i[c]) && (trig_i[c] || !disc_trg_i[c])));

      a_r3_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dis_i[c] && lo_since_q != '0 && lo_since_q <= min_eff + SW'(2)) |-> time_i[c]);

      a_r4_hold_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dis_i[c] && hi_since_q != '0 && hi_since_q <= hold_eff + SW'(2)) |-> time_i[c]);
    end
  endgenerate
endmodule

bind pulse_shaper pulse_shaper_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .disc_lo_i (disc_lo_i),
  .disc_hi_i (disc_hi_i),
  .disc_cnt_i(disc_cnt_i),
  .disc_trg_i(disc_trg_i),
  .time_i    (time_o),
  .count_i   (count_o),
  .trig_i    (trig_o),
  .dis_i     (dis_q),
  .len_i     (len_cfg)
);

// File: tb/pulse_shaper_test.sv
`timescale 1ns/1ps
module pulse_shaper_test;
  localparam int NCH = 9;
  localparam int DW  = 16;
  localparam int INV = -1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [NCH-1:0] lo_i = '0, hi_i = '0, cn_i = '0, tg_i = '0;
  logic [NCH-1:0] time_o, count_o, trig_o;

  always #4 clk = ~clk;

  pulse_shaper #(.NCH(NCH), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .disc_lo_i(lo_i), .disc_hi_i(hi_i), .disc_cnt_i(cn_i), .disc_trg_i(tg_i),
    .time_o(time_o), .count_o(count_o), .trig_o(trig_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // next-cycle stimulus
  logic [NCH-1:0] n_lo = '0, n_hi = '0, n_cn = '0, n_tg = '0;
  logic n_we = 1'b0;
  logic [2:0] n_addr = '0;
  logic [DW-1:0] n_wd = '0;

  // model state
  int e = 0;
  int sh_min = 5, sh_hold = 8, sh_cnt = 5, sh_trg = 5;
  logic [NCH-1:0] sh_dis = '0;
  logic [NCH-1:0] v_lo = '0, v_hi = '0, v_cn = '0, v_tg = '0;
  int rk_lo[NCH], rk_cn[NCH], rk_tg[NCH], jh[NCH];

  function automatic int leff(int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic logic win(int k, int l);
    return (e >= k + 1) && (e <= k + 1 + leff(l));
  endfunction

  task automatic model_edge();
    e++;
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: sh_min  = int'(cfg_wdata[7:0]);
        3'd1: sh_hold = int'(cfg_wdata[7:0]);
        3'd2: sh_cnt  = int'(cfg_wdata[7:0]);
        3'd3: sh_trg  = int'(cfg_wdata[7:0]);
        3'd4: sh_dis  = cfg_wdata[NCH-1:0];
        default: ;
      endcase
    end
    for (int c = 0; c < NCH; c++) begin
      if (sh_dis[c]) begin
        rk_lo[c] = INV; rk_cn[c] = INV; rk_tg[c] = INV; jh[c] = INV;
      end else begin
        if (lo_i[c] && !v_lo[c]) rk_lo[c] = e;
        if (cn_i[c] && !v_cn[c]) rk_cn[c] = e;
        if (tg_i[c] && !v_tg[c]) rk_tg[c] = e;
        if (hi_i[c]) jh[c] = e;
      end
    end
    v_lo = lo_i; v_hi = hi_i; v_cn = cn_i; v_tg = tg_i;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, e, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [NCH-1:0] et, ec, eg;
    for (int c = 0; c < NCH; c++) begin
      et[c] = !sh_dis[c] && (lo_i[c] || hi_i[c] || v_lo[c] || win(rk_lo[c], sh_min)
                             || (e <= jh[c] + 1 + leff(sh_hold)));
      ec[c] = !sh_dis[c] && (cn_i[c] || v_cn[c] || win(rk_cn[c], sh_cnt));
      eg[c] = !sh_dis[c] && (tg_i[c] || v_tg[c] || win(rk_tg[c], sh_trg));
    end
    chk(tag, "time", time_o, et);
    chk(tag, "count", count_o, ec);
    chk(tag, "trig", trig_o, eg);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    lo_i = n_lo; hi_i = n_hi; cn_i = n_cn; tg_i = n_tg;
    cfg_we = n_we; cfg_addr = n_addr; cfg_wdata = n_wd;
    n_we = 1'b0;
    #4;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    n_lo = '0; n_hi = '0; n_cn = '0; n_tg = '0;
    repeat (n) step(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input string tag);
    n_we = 1'b1; n_addr = a; n_wd = d;
    step(tag);
  endtask

  task automatic rnd(input int n, input string tag);
    repeat (n) begin
      n_lo = NCH'($urandom & $urandom);
      n_hi = n_lo & NCH'($urandom);
      n_cn = NCH'($urandom & $urandom & $urandom);
      n_tg = NCH'($urandom & $urandom);
      step(tag);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1a2b3c);
    for (int c = 0; c < NCH; c++) begin
      rk_lo[c] = INV; rk_cn[c] = INV; rk_tg[c] = INV; jh[c] = INV;
    end
    repeat (3) @(posedge clk);
    #3;
    chk("R1", "time in reset", time_o, '0);
    chk("R1", "count in reset", count_o, '0);
    chk("R1", "trig in reset", trig_o, '0);
    @(posedge clk);
    #2 rst_ni = 1'b1;
    #4;
    compare("R1");
    idle(4, "R1");

    // R2 leading edge, R3 minimum width, R6 count/trigger stretch with defaults
    n_lo = 9'h001; n_cn = 9'h002; n_tg = 9'h004;
    step("R2");
    idle(12, "R3");
    n_cn = 9'h002; n_tg = 9'h004;
    repeat (3) step("R6");
    idle(12, "R6");

    // R4 hold after high threshold falls
    n_lo = 9'h010; n_hi = 9'h010;
    repeat (2) step("R4");
    idle(15, "R4");

    // R5 low level outlasts the hold
    n_lo = 9'h020; n_hi = 9'h020;
    repeat (3) step("R5");
    n_hi = '0;
    repeat (20) step("R5");
    idle(15, "R5");

    // R7 retrigger during active stretch
    repeat (5) begin
      n_cn = 9'h040; step("R7");
      n_cn = '0;     step("R7");
      step("R7");
    end
    idle(12, "R7");

    // R8 zero length acts as one tick
    wr(3'd2, 16'h0000, "R8");
    idle(5, "R8");
    n_cn = 9'h080; step("R8");
    idle(8, "R8");

    // R10 unmapped addresses ignored, then a new length set
    wr(3'd6, 16'h00ff, "R10");
    wr(3'd5, 16'h01ff, "R10");
    wr(3'd7, 16'h0033, "R10");
    idle(4, "R10");
    n_cn = 9'h100; n_lo = 9'h100; step("R10");
    idle(12, "R10");
    wr(3'd0, 16'h0003, "R10");
    wr(3'd1, 16'h000c, "R10");
    wr(3'd2, 16'h0007, "R10");
    wr(3'd3, 16'h0002, "R10");
    idle(4, "R10");
    n_lo = 9'h003; n_hi = 9'h002; n_cn = 9'h00c; n_tg = 9'h030; step("R10");
    idle(20, "R10");

    // R9 disable mask
    wr(3'd4, 16'h0108, "R9");
    rnd(300, "R9");
    idle(30, "R9");
    wr(3'd4, 16'h0000, "R9");
    idle(5, "R9");

    // random blocks with varied lengths
    for (int b = 0; b < 6; b++) begin
      idle(20, "R7");
      wr(3'd0, DW'($urandom_range(0, 15)), "R10");
      wr(3'd1, DW'($urandom_range(0, 15)), "R10");
      wr(3'd2, DW'($urandom_range(0, 15)), "R10");
      wr(3'd3, DW'($urandom_range(0, 15)), "R10");
      idle(3, "R6");
      rnd(400, "R2");
    end
    idle(20, "R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule